// File: doc/BRIEF.md
# Parallel Port FIFO Service Request Controller

This block holds a 16-slot byte queue between the host and the peripheral side of an extended-capability parallel port. It also decides when the host must be asked for attention. A direction input picks which side fills the queue and which side drains it. The host programs a 4-bit threshold code, and the effective threshold is that code plus one. In the transmit direction the block compares the number of free slots with the threshold. In the receive direction it compares the number of stored bytes with the threshold.

A software-visible service mask bit gates all service activity. While the mask is 1 there are no DMA requests and no service or terminal-count interrupts. When software clears the mask, the block acts on the current state. With DMA enabled it holds a DMA request while the threshold condition is true. With DMA disabled it sends a one-cycle interrupt pulse. If the condition already holds when the mask is cleared, the pulse comes at once. Two other events also give an interrupt: a DMA terminal-count strobe, and edges on the synchronized fault and acknowledge pins. When a service or terminal-count interrupt fires, hardware sets the mask to 1 again so that it does not retrigger.

Top module: `ppf_service_top`

## Requirements
- R1: The queue stores up to 16 bytes and returns them in arrival order. A write while `fifo_full` is 1 is dropped, and a read while `fifo_empty` is 1 is dropped.
- R2: With `dir`=0, `host_wr` fills the queue and `per_pop` drains it. With `dir`=1, `per_push` fills it and `host_rd` drains it. The fill and drain strobes of the inactive sides are ignored.
- R3: The effective threshold is `thr_code`+1, so it ranges from 1 to 16. With `dir`=0 the condition is (16 − stored) ≥ threshold. With `dir`=1 the condition is stored ≥ threshold.
- R4: When `svc_mask`=0, `dma_en`=1 and the condition holds in a cycle, `dma_req` is 1 in the next cycle. When the condition is false, `dma_req` is 0 in the next cycle.
- R5: While `svc_mask`=1, `dma_req` stays 0 and neither the threshold condition nor `tc_strobe` produces an interrupt.
- R6: When `svc_mask`=0, `dma_en`=0 and the condition holds, an interrupt pulse is raised. This includes the case where the condition was already true at the moment software cleared the mask.
- R7: A service interrupt or a terminal-count interrupt sets `svc_mask` to 1, and software must write it to 0 again.
- R8: When `svc_mask`=0 and `dma_en`=1, a `tc_strobe` cycle raises an interrupt pulse.
- R9: While `err_ie_n`=0, a high-to-low edge on `fault_n` raises an interrupt. A change of `err_ie_n` from 1 to 0 while `fault_n` is already low also raises one. While `err_ie_n`=1, a falling edge of `fault_n` does nothing.
- R10: While `ack_ie`=1, a low-to-high edge on `ack_n` raises an interrupt. A falling edge of `ack_n` does nothing, and while `ack_ie`=0 no edge of `ack_n` does anything.
- R11: `irq` is registered. Each interrupt event gives a pulse exactly one cycle wide.
- R12: After reset the queue is empty, `svc_mask`=1, and `irq`=0 and `dma_req`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host byte write strobe (used when dir=0) |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host byte read strobe (used when dir=1) |
| host_rdata | output | 8 | Byte at the head of the queue |
| per_push | input | 1 | Peripheral push strobe (used when dir=1) |
| per_wdata | input | 8 | Peripheral push byte |
| per_pop | input | 1 | Peripheral pop strobe (used when dir=0) |
| per_rdata | output | 8 | Byte at the head of the queue |
| fifo_full | output | 1 | Queue holds 16 bytes |
| fifo_empty | output | 1 | Queue holds no bytes |
| dir | input | 1 | 0 = host to peripheral, 1 = peripheral to host |
| dma_en | input | 1 | Selects DMA servicing instead of programmed I/O |
| thr_code | input | 4 | Threshold code, effective threshold = code + 1 |
| svc_wr | input | 1 | Software write strobe for the service mask |
| svc_wdata | input | 1 | Value written to the service mask |
| svc_mask | output | 1 | Current service mask bit |
| err_ie_n | input | 1 | Fault interrupt enable, active low |
| ack_ie | input | 1 | Acknowledge interrupt enable |
| fault_n | input | 1 | Asynchronous fault pin, active low |
| ack_n | input | 1 | Asynchronous acknowledge pin |
| tc_strobe | input | 1 | DMA terminal-count cycle indication |
| irq | output | 1 | Interrupt pulse |
| dma_req | output | 1 | DMA service request level |

## Verification
The hardest case to reach is the one where the mask is cleared while the threshold condition already holds. The interrupt must then come from the level alone, with no byte crossing the threshold. To set it up, the stimulus fills the queue to a chosen level while the mask is still 1 from reset, and only then writes the mask to 0. A table of direction, threshold code and byte count covers the ends of both comparisons (empty, full, threshold 1 and threshold 16). Each row is checked once as a DMA request level and once as a single interrupt pulse that sets the mask again. The pin checks hold each pin level for several cycles, so that the synchronizer delay is covered, and then count the pulses.

// File: rtl/ppf_pkg.sv
`timescale 1ns/1ps
package ppf_pkg;
    localparam int FIFO_DEPTH = 16;
    localparam int BYTE_W     = 8;
    localparam int THR_W      = 4;
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1);
    localparam int SYNC_STAGES = 2;

    typedef enum logic {
        DIR_TO_PERIPH = 1'b0,
        DIR_TO_HOST   = 1'b1
    } xfer_dir_e;

    typedef struct packed {
        logic svc;
        logic tc;
        logic fault;
        logic ack;
    } irq_src_t;

    typedef struct packed {
        logic             wr;
        logic [BYTE_W-1:0] wdata;
        logic             rd;
    } fifo_req_t;

    function automatic logic [CNT_W-1:0] eff_threshold(input logic [THR_W-1:0] code);
        return CNT_W'(code) + CNT_W'(1);
    endfunction

    function automatic logic threshold_met(input xfer_dir_e d,
                                           input logic [CNT_W-1:0] fill,
                                           input logic [THR_W-1:0] code);
        logic [CNT_W-1:0] free_slots;
        free_slots = CNT_W'(FIFO_DEPTH) - fill;
        if (d == DIR_TO_HOST)
            return fill >= eff_threshold(code);
        else
            return free_slots >= eff_threshold(code);
    endfunction
endpackage

// File: rtl/ppf_byte_fifo.sv
`timescale 1ns/1ps
module ppf_byte_fifo #(
    parameter int DEPTH = ppf_pkg::FIFO_DEPTH,
    parameter int W     = ppf_pkg::BYTE_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  ppf_pkg::fifo_req_t           req,
    output logic [W-1:0]                 head,
    output logic [$clog2(DEPTH+1)-1:0]   fill,
    output logic                         full,
    output logic                         empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;
    logic          do_wr, do_rd;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign full  = (cnt == CW'(DEPTH));
    assign empty = (cnt == '0);
    assign do_wr = req.wr && !full;
    assign do_rd = req.rd && !empty;
    assign head  = mem[rd_ptr];
    assign fill  = cnt;

    always_ff @(posedge clk) begin
        if (do_wr)
            mem[wr_ptr] <= req.wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_wr) wr_ptr <= bump(wr_ptr);
            if (do_rd) rd_ptr <= bump(rd_ptr);
            case ({do_wr, do_rd})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/ppf_pin_edge.sv
`timescale 1ns/1ps
module ppf_pin_edge #(
    parameter int   STAGES    = ppf_pkg::SYNC_STAGES,
    parameter logic IDLE_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic level,
    output logic rose,
    output logic fell
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{IDLE_LEVEL}};
            prev  <= IDLE_LEVEL;
        end else begin
            chain <= {chain[STAGES-2:0], pin};
            prev  <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];
    assign rose  = level && !prev;
    assign fell  = !level && prev;
endmodule

// File: rtl/ppf_irq_ctl.sv
`timescale 1ns/1ps
module ppf_irq_ctl (
    input  logic clk,
    input  logic rst,
    input  logic thr_met,
    input  logic dma_en,
    input  logic svc_wr,
    input  logic svc_wdata,
    input  logic tc_strobe,
    input  logic err_ie_n,
    input  logic fault_level,
    input  logic fault_fell,
    input  logic ack_ie,
    input  logic ack_rose,
    output logic svc_mask,
    output logic irq,
    output logic dma_req
);
    import ppf_pkg::*;

    logic     svc_q, irq_q, dma_q, err_ie_n_d;
    irq_src_t src;

    always_comb begin
        src.svc   = !svc_q && !dma_en && thr_met;
        src.tc    = !svc_q &&  dma_en && tc_strobe;
        src.fault = (!err_ie_n && fault_fell) ||
                    (err_ie_n_d && !err_ie_n && !fault_level);
        src.ack   = ack_ie && ack_rose;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            svc_q      <= 1'b1;
            irq_q      <= 1'b0;
            dma_q      <= 1'b0;
            err_ie_n_d <= 1'b1;
        end else begin
            if (svc_wr)
                svc_q <= svc_wdata;
            else if (src.svc || src.tc)
                svc_q <= 1'b1;
            irq_q      <= |src;
            dma_q      <= !svc_q && dma_en && thr_met;
            err_ie_n_d <= err_ie_n;
        end
    end

    assign svc_mask = svc_q;
    assign irq      = irq_q;
    assign dma_req  = dma_q;
endmodule

// File: rtl/ppf_service_top.sv
`timescale 1ns/1ps
module ppf_service_top #(
    parameter int DEPTH = ppf_pkg::FIFO_DEPTH,
    parameter int W     = ppf_pkg::BYTE_W,
    parameter int TW    = ppf_pkg::THR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_wr,
    input  logic [W-1:0]  host_wdata,
    input  logic          host_rd,
    output logic [W-1:0]  host_rdata,
    input  logic          per_push,
    input  logic [W-1:0]  per_wdata,
    input  logic          per_pop,
    output logic [W-1:0]  per_rdata,
    output logic          fifo_full,
    output logic          fifo_empty,
    input  logic          dir,
    input  logic          dma_en,
    input  logic [TW-1:0] thr_code,
    input  logic          svc_wr,
    input  logic          svc_wdata,
    output logic          svc_mask,
    input  logic          err_ie_n,
    input  logic          ack_ie,
    input  logic          fault_n,
    input  logic          ack_n,
    input  logic          tc_strobe,
    output logic          irq,
    output logic          dma_req
);
    import ppf_pkg::*;
    localparam int CW = $clog2(DEPTH + 1);

    fifo_req_t req;
    xfer_dir_e xdir;
    logic [W-1:0]  head;
    logic [CW-1:0] fill_cnt;
    logic          thr_met;
    logic          fault_level, fault_rose, fault_fell;
    logic          ack_level, ack_rose, ack_fell;

    assign xdir = xfer_dir_e'(dir);

    always_comb begin
        if (xdir == DIR_TO_HOST) begin
            req.wr    = per_push;
            req.wdata = per_wdata;
            req.rd    = host_rd;
        end else begin
            req.wr    = host_wr;
            req.wdata = host_wdata;
            req.rd    = per_pop;
        end
    end

    ppf_byte_fifo #(.DEPTH(DEPTH), .W(W)) u_fifo (
        .clk(clk), .rst(rst), .req(req), .head(head),
        .fill(fill_cnt), .full(fifo_full), .empty(fifo_empty)
    );

    assign host_rdata = head;
    assign per_rdata  = head;
    assign thr_met    = threshold_met(xdir, fill_cnt, thr_code);

    ppf_pin_edge #(.STAGES(SYNC_STAGES), .IDLE_LEVEL(1'b1)) u_fault_sync (
        .clk(clk), .rst(rst), .pin(fault_n),
        .level(fault_level), .rose(fault_rose), .fell(fault_fell)
    );

    ppf_pin_edge #(.STAGES(SYNC_STAGES), .IDLE_LEVEL(1'b1)) u_ack_sync (
        .clk(clk), .rst(rst), .pin(ack_n),
        .level(ack_level), .rose(ack_rose), .fell(ack_fell)
    );

    ppf_irq_ctl u_irq (
        .clk(clk), .rst(rst), .thr_met(thr_met), .dma_en(dma_en),
        .svc_wr(svc_wr), .svc_wdata(svc_wdata), .tc_strobe(tc_strobe),
        .err_ie_n(err_ie_n), .fault_level(fault_level), .fault_fell(fault_fell),
        .ack_ie(ack_ie), .ack_rose(ack_rose),
        .svc_mask(svc_mask), .irq(irq), .dma_req(dma_req)
    );
endmodule

// File: rtl/ppf_checker.sv
`timescale 1ns/1ps
module ppf_checker #(
    parameter int DEPTH = ppf_pkg::FIFO_DEPTH,
    parameter int CW    = $clog2(ppf_pkg::FIFO_DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          svc_mask,
    input logic          svc_wr,
    input logic          dma_en,
    input logic          thr_met,
    input logic          tc_strobe,
    input logic          irq,
    input logic          dma_req,
    input logic          fifo_full,
    input logic          fifo_empty,
    input logic [CW-1:0] fill
);
    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (rst)
        fill <= CW'(DEPTH));

    assert_flags_exclusive_R1: assert property (@(posedge clk) disable iff (rst)
        !(fifo_full && fifo_empty));

    assert_dma_follows_R4: assert property (@(posedge clk) disable iff (rst)
        (!svc_mask && dma_en && thr_met) |=> dma_req);

    assert_mask_blocks_dma_R5: assert property (@(posedge clk) disable iff (rst)
        svc_mask |=> !dma_req);

    assert_pio_service_irq_R6: assert property (@(posedge clk) disable iff (rst)
        (!svc_mask && !dma_en && thr_met) |=> irq);

    assert_hw_sets_mask_R7: assert property (@(posedge clk) disable iff (rst)
        (!svc_mask && !dma_en && thr_met && !svc_wr) |=> svc_mask);

    assert_tc_irq_R8: assert property (@(posedge clk) disable iff (rst)
        (!svc_mask && dma_en && tc_strobe) |=> irq);
endmodule

bind ppf_service_top ppf_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst(rst), .svc_mask(svc_mask), .svc_wr(svc_wr),
    .dma_en(dma_en), .thr_met(thr_met), .tc_strobe(tc_strobe),
    .irq(irq), .dma_req(dma_req), .fifo_full(fifo_full),
    .fifo_empty(fifo_empty), .fill(fill_cnt)
);

// File: tb/tb_ppf_service_top.sv
`timescale 1ns/1ps
module tb_ppf_service_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr = 0, host_rd = 0, per_push = 0, per_pop = 0;
    logic [7:0] host_wdata = 0, per_wdata = 0, host_rdata, per_rdata;
    logic       fifo_full, fifo_empty;
    logic       dir = 0, dma_en = 0, svc_wr = 0, svc_wdata = 0, svc_mask;
    logic [3:0] thr_code = 0;
    logic       err_ie_n = 1, ack_ie = 0, fault_n = 1, ack_n = 1, tc_strobe = 0;
    logic       irq, dma_req;

    int n_checks = 0, n_fail = 0, pulses = 0, run = 0, max_run = 0;

    always #2.5 clk = ~clk;

    ppf_service_top dut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rd(host_rd), .host_rdata(host_rdata), .per_push(per_push),
        .per_wdata(per_wdata), .per_pop(per_pop), .per_rdata(per_rdata),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty), .dir(dir),
        .dma_en(dma_en), .thr_code(thr_code), .svc_wr(svc_wr),
        .svc_wdata(svc_wdata), .svc_mask(svc_mask), .err_ie_n(err_ie_n),
        .ack_ie(ack_ie), .fault_n(fault_n), .ack_n(ack_n),
        .tc_strobe(tc_strobe), .irq(irq), .dma_req(dma_req)
    );

    always @(negedge clk) begin
        if (!rst && irq) begin
            pulses++;
            run++;
            if (run > max_run) max_run = run;
        end else begin
            run = 0;
        end
    end

    // {dir, thr_code[3:0], bytes[4:0], expected condition}
    localparam logic [10:0] VEC [10] = '{
        {1'b0, 4'd3,  5'd12, 1'b1},
        {1'b0, 4'd3,  5'd13, 1'b0},
        {1'b1, 4'd3,  5'd4,  1'b1},
        {1'b1, 4'd3,  5'd3,  1'b0},
        {1'b1, 4'd15, 5'd16, 1'b1},
        {1'b1, 4'd15, 5'd15, 1'b0},
        {1'b0, 4'd15, 5'd0,  1'b1},
        {1'b0, 4'd0,  5'd16, 1'b0},
        {1'b1, 4'd0,  5'd0,  1'b0},
        {1'b1, 4'd0,  5'd1,  1'b1}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst = 1; host_wr = 0; host_rd = 0; per_push = 0; per_pop = 0;
        dir = 0; dma_en = 0; svc_wr = 0; thr_code = 0; err_ie_n = 1;
        ack_ie = 0; fault_n = 1; ack_n = 1; tc_strobe = 0;
        cyc(3);
        rst = 0;
        cyc(1);
    endtask

    task automatic put(input logic side_per, input logic [7:0] b);
        if (side_per) begin per_push = 1; per_wdata = b; end
        else          begin host_wr = 1;  host_wdata = b; end
        cyc(1);
        per_push = 0; host_wr = 0;
    endtask

    task automatic write_mask(input logic v);
        svc_wr = 1; svc_wdata = v;
        cyc(1);
        svc_wr = 0;
    endtask

    initial begin
        #(5.0 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int p0;
        // R12: reset state
        do_reset();
        @(negedge clk);
        chk("R12 empty", fifo_empty, 1);
        chk("R12 svc_mask", svc_mask, 1);
        chk("R12 irq", irq, 0);
        chk("R12 dma_req", dma_req, 0);

        // R3 R4 R6 R7: table walk
        foreach (VEC[k]) begin
            do_reset();
            dir = VEC[k][10]; thr_code = VEC[k][9:6]; dma_en = 1;
            for (int j = 0; j < int'(VEC[k][5:1]); j++) put(VEC[k][10], 8'(j));
            cyc(1);
            p0 = pulses;
            write_mask(0);
            cyc(2);
            @(negedge clk);
            chk($sformatf("R4 R3 dma_req vec%0d", k), dma_req, VEC[k][0]);
            chk($sformatf("R4 no irq vec%0d", k), pulses - p0, 0);
            #1;
            dma_en = 0;
            cyc(4);
            @(negedge clk);
            chk($sformatf("R6 pulses vec%0d", k), pulses - p0, VEC[k][0]);
            chk($sformatf("R7 mask vec%0d", k), svc_mask, VEC[k][0]);
        end

        // R1 R2: ordering, overflow, port routing
        do_reset();
        for (int j = 0; j < 17; j++) put(0, 8'(j * 7 + 3));
        @(negedge clk);
        chk("R1 full", fifo_full, 1);
        #1;
        per_push = 1; per_wdata = 8'hEE; host_rd = 1;
        cyc(1);
        per_push = 0; host_rd = 0;
        for (int j = 0; j < 16; j++) begin
            @(negedge clk);
            chk($sformatf("R1 order %0d", j), per_rdata, (j * 7 + 3) & 8'hFF);
            #1; per_pop = 1; cyc(1); per_pop = 0;
        end
        @(negedge clk);
        chk("R1 empty after drain", fifo_empty, 1);
        #1;
        per_pop = 1; cyc(1); per_pop = 0;
        put(0, 8'h5A);
        @(negedge clk);
        chk("R1 pop on empty dropped", per_rdata, 8'h5A);
        #1;
        dir = 1;
        per_pop = 1; cyc(1); per_pop = 0;
        @(negedge clk);
        chk("R2 per_pop ignored dir1", fifo_empty, 0);
        #1;
        host_rd = 1; cyc(1); host_rd = 0;
        @(negedge clk);
        chk("R2 host_rd drains dir1", fifo_empty, 1);

        // R5: mask set suppresses requests and tc
        do_reset();
        dir = 1; thr_code = 0; dma_en = 1;
        put(1, 8'h11);
        p0 = pulses;
        tc_strobe = 1; cyc(1); tc_strobe = 0;
        cyc(3);
        @(negedge clk);
        chk("R5 dma_req masked", dma_req, 0);
        chk("R5 no irq masked", pulses - p0, 0);
        #1;
        dma_en = 0;
        cyc(3);
        @(negedge clk);
        chk("R5 no pio irq masked", pulses - p0, 0);

        // R8: terminal count in DMA mode
        do_reset();
        dma_en = 1;
        write_mask(0);
        p0 = pulses;
        tc_strobe = 1; cyc(1); tc_strobe = 0;
        cyc(2);
        @(negedge clk);
        chk("R8 tc pulse", pulses - p0, 1);
        chk("R7 mask after tc", svc_mask, 1);

        // R9: fault pin
        do_reset();
        err_ie_n = 0;
        cyc(2);
        p0 = pulses;
        fault_n = 0; cyc(6);
        chk("R9 fall enabled", pulses - p0, 1);
        fault_n = 1; err_ie_n = 1; cyc(6);
        p0 = pulses;
        fault_n = 0; cyc(6);
        chk("R9 fall disabled", pulses - p0, 0);
        err_ie_n = 0; cyc(6);
        chk("R9 enable while low", pulses - p0, 1);

        // R10: acknowledge pin
        do_reset();
        ack_ie = 1;
        p0 = pulses;
        ack_n = 0; cyc(6);
        chk("R10 fall ignored", pulses - p0, 0);
        ack_n = 1; cyc(6);
        chk("R10 rise", pulses - p0, 1);
        ack_ie = 0;
        ack_n = 0; cyc(6); ack_n = 1; cyc(6);
        chk("R10 disabled", pulses - p0, 1);

        // R11: every pulse was one cycle wide
        chk("R11 pulse width", max_run, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule